// File: doc/BRIEF.md
# UART Receive Byte Queue with Status

This block sits between a serial receiver and a register-mapped host. Each byte the receiver delivers is queued in a small first-in first-out store. The host drains that store through a holding-register read, and can read an occupancy/full word and a sticky line-error word. A control register selects between queued operation and a single-register mode. In single-register mode every new byte replaces the previous one.

A line-break event from the receiver enters the data stream as a zero byte and is flagged in the error word. Two level interrupt requests come out of the block: one for received data, one for error conditions. Queue underflow and overflow drive the error request. The host clears either request by writing a clear mask. Reads of the holding register and the error word have side effects, which take effect on the clock edge that ends the read cycle. Read data is valid in the same cycle as `rd_en`.

Top module: `uart_rxq`

## Requirements
- R1: After reset the occupancy is 0, `data_ready`, `irq_rx` and `irq_err` are low, the control word reads 0 (single-register mode) and the error word reads 0.
- R2: With control bit 0 set (queue mode), bytes read from the holding register (`rd_sel`=0) come out in arrival order. Status word (`rd_sel`=1) bits [7:0] give the occupancy whenever the queue is not full.
- R3: When the queue holds DEPTH bytes, status bits [7:0] read 0 and bit 8 reads 1. A byte that arrives while full is discarded. It sets error bit 0 (overrun) and the error request, and `data_ready` stays high.
- R4: A holding-register read in queue mode while the queue is empty returns 0, sets the error request and leaves the occupancy at 0.
- R5: In queue mode `data_ready` stays high while bytes remain and drops after the read that removes the last byte.
- R6: In single-register mode a received byte overwrites the holding register and sets `data_ready` and the data request. A holding-register read returns the latest byte and clears `data_ready`.
- R7: A pulse on `rx_break` stores a zero byte like a received byte and sets error bit 3.
- R8: A received byte with `rx_perr` sets error bit 1 and one with `rx_ferr` sets error bit 2. Status bit 9 is high while any error bit is set. Reading the error word (`rd_sel`=2) returns it and clears it to 0.
- R9: Writing control bit 1 empties the queue at once. The control word (`rd_sel`=3) always reads that bit as 0 and keeps only the mode bit in bit 0.
- R10: Each received byte or break sets the data request. `irq_rx` and `irq_err` follow their sources until a write with `src_clr` bit 0 (data) or bit 1 (error) clears them. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | Receiver delivers a byte this cycle |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error flag for the delivered byte |
| rx_ferr | input | 1 | Framing error flag for the delivered byte |
| rx_break | input | 1 | Line-break event pulse |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 2 | Bit 0 queue enable, bit 1 queue flush |
| src_clr_we | input | 1 | Write strobe for the interrupt-source clear mask |
| src_clr | input | 2 | Bit 0 clears data request, bit 1 clears error request |
| rd_en | input | 1 | Host read strobe (side effects on this edge) |
| rd_sel | input | 2 | 0 holding, 1 status, 2 error word, 3 control |
| rd_data | output | 32 | Read data for the selected word |
| data_ready | output | 1 | Received data available |
| irq_rx | output | 1 | Data interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The bench fills the queue to exactly DEPTH. It checks that the count field folds to 0 with the full bit set. A design that let the count reach 16 in the field, or kept the overflowing byte, would read back 0x10 or an extra 0xEE. It drains the queue one byte at a time to catch a `data_ready` that drops too early or sticks high, and reads past empty to check the zero return and the error request. It also checks that the error word clears on read but gathers parity and break bits first, that a flush empties a half-full queue while the flush bit reads 0, and that single-register mode keeps only the newest byte.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  typedef enum logic [1:0] {
    SEL_HOLD  = 2'd0,
    SEL_FSTAT = 2'd1,
    SEL_ESTAT = 2'd2,
    SEL_CTRL  = 2'd3
  } rd_sel_e;

  localparam int ERR_OVR = 0;
  localparam int ERR_PAR = 1;
  localparam int ERR_FRM = 2;
  localparam int ERR_BRK = 3;
  localparam int ERR_W   = 4;

  localparam int STAT_FULL_BIT = 8;
  localparam int STAT_ERR_BIT  = 9;

  localparam int SRC_RX  = 0;
  localparam int SRC_ERR = 1;

endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] occ_q, occ_d;
  logic          push_ok, pop_ok;

  assign full    = (occ_q == FULLC);
  assign empty   = (occ_q == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    occ_d  = occ_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      occ_d  = '0;
    end else begin
      if (push_ok) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (pop_ok)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   occ_d = occ_q + 1'b1;
        2'b01:   occ_d = occ_q - 1'b1;
        default: occ_d = occ_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      occ_q  <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= din;
  end

  assign dout = mem[rptr_q];
  assign occ  = occ_q;

endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import uart_rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] err_set,
  input  logic             err_rd,
  input  logic [1:0]       src_set,
  input  logic             src_clr_we,
  input  logic [1:0]       src_clr,
  output logic [ERR_W-1:0] err_bits,
  output logic [1:0]       src
);

  logic [ERR_W-1:0] err_q, err_d;
  logic [1:0]       src_q, src_d;
  logic             err_en, src_en;

  assign err_en = err_rd || (err_set != '0);
  assign src_en = src_clr_we || (src_set != '0);

  always_comb begin
    err_d = (err_rd ? '0 : err_q) | err_set;
    src_d = (src_clr_we ? (src_q & ~src_clr) : src_q) | src_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      src_q <= '0;
    end else begin
      if (err_en) err_q <= err_d;
      if (src_en) src_q <= src_d;
    end
  end

  assign err_bits = err_q;
  assign src      = src_q;

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_perr,
  input  logic        rx_ferr,
  input  logic        rx_break,
  input  logic        ctl_we,
  input  logic [1:0]  ctl_wdata,
  input  logic        src_clr_we,
  input  logic [1:0]  src_clr,
  input  logic        rd_en,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        data_ready,
  output logic        irq_rx,
  output logic        irq_err
);

  localparam int CW = $clog2(DEPTH + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // control word: only the mode bit is stored
  logic fifo_en, fifo_en_d, flush;

  assign flush     = ctl_we && ctl_wdata[1];
  assign fifo_en_d = ctl_we ? ctl_wdata[0] : fifo_en;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) fifo_en <= 1'b0;
    else             fifo_en <= fifo_en_d;
  end

  // incoming byte path (break enters as a zero byte)
  logic       byte_in_vld;
  logic [7:0] byte_in;
  logic       rd_hold, rd_err;

  assign byte_in_vld = rx_valid || rx_break;
  assign byte_in     = rx_break ? 8'h00 : rx_byte;
  assign rd_hold     = rd_en && (rd_sel == SEL_HOLD);
  assign rd_err      = rd_en && (rd_sel == SEL_ESTAT);

  // queue
  logic [7:0]    q_dout;
  logic [CW-1:0] occ;
  logic          q_full, q_empty, q_push, q_pop;

  assign q_push = fifo_en && byte_in_vld;
  assign q_pop  = fifo_en && rd_hold;

  rxq_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .flush (flush),
    .push  (q_push),
    .din   (byte_in),
    .pop   (q_pop),
    .dout  (q_dout),
    .occ   (occ),
    .full  (q_full),
    .empty (q_empty)
  );

  // single holding register
  logic [7:0] hold_q, hold_d;
  logic       hold_vld_q, hold_vld_d, hold_en;

  assign hold_en = !fifo_en && (byte_in_vld || rd_hold);

  always_comb begin
    hold_d     = hold_q;
    hold_vld_d = hold_vld_q;
    if (byte_in_vld) begin
      hold_d     = byte_in;
      hold_vld_d = 1'b1;
    end else if (rd_hold) begin
      hold_vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else if (hold_en) begin
      hold_q     <= hold_d;
      hold_vld_q <= hold_vld_d;
    end
  end

  // error word and interrupt sources
  logic             overflow, underflow;
  logic [ERR_W-1:0] err_set, err_bits;
  logic [1:0]       src_set, src;

  assign overflow  = q_push && q_full;
  assign underflow = q_pop && q_empty;

  always_comb begin
    err_set          = '0;
    err_set[ERR_OVR] = overflow;
    err_set[ERR_PAR] = rx_valid && rx_perr;
    err_set[ERR_FRM] = rx_valid && rx_ferr;
    err_set[ERR_BRK] = rx_break;
    src_set          = '0;
    src_set[SRC_RX]  = byte_in_vld;
    src_set[SRC_ERR] = overflow || underflow;
  end

  rxq_status u_status (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .err_set    (err_set),
    .err_rd     (rd_err),
    .src_set    (src_set),
    .src_clr_we (src_clr_we),
    .src_clr    (src_clr),
    .err_bits   (err_bits),
    .src        (src)
  );

  // read mux
  logic [7:0] occ_field;
  assign occ_field = q_full ? 8'h00 : 8'(occ);

  always_comb begin
    rd_data = '0;
    case (rd_sel_e'(rd_sel))
      SEL_HOLD: begin
        if (fifo_en) rd_data[7:0] = q_empty ? 8'h00 : q_dout;
        else         rd_data[7:0] = hold_q;
      end
      SEL_FSTAT: begin
        rd_data[7:0]          = occ_field;
        rd_data[STAT_FULL_BIT] = q_full;
        rd_data[STAT_ERR_BIT]  = (err_bits != '0);
      end
      SEL_ESTAT: rd_data[ERR_W-1:0] = err_bits;
      SEL_CTRL:  rd_data[0] = fifo_en;
      default:   rd_data = '0;
    endcase
  end

  assign data_ready = fifo_en ? !q_empty : hold_vld_q;
  assign irq_rx     = src[SRC_RX];
  assign irq_err    = src[SRC_ERR];

endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             rx_break,
  input logic             ctl_we,
  input logic [1:0]       ctl_wdata,
  input logic             rd_en,
  input logic [1:0]       rd_sel,
  input logic             data_ready,
  input logic             irq_rx,
  input logic             irq_err,
  input logic             fifo_en,
  input logic [CW-1:0]    occ,
  input logic [ERR_W-1:0] err_bits
);

  a_r3_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  a_r4_underflow_err: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == SEL_HOLD && fifo_en && occ == '0) |=> irq_err);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rd_en && rd_sel == SEL_HOLD && !rx_valid && !rx_break && !ctl_we)
      |=> !data_ready);

  a_r7_break_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> err_bits[ERR_BRK]);

  a_r8_err_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == SEL_ESTAT && !rx_valid && !rx_break) |=> (err_bits == '0));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[1]) |=> (occ == '0));

  a_r10_rx_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx) |-> $past(rx_valid || rx_break));

endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .rx_valid   (rx_valid),
  .rx_break   (rx_break),
  .ctl_we     (ctl_we),
  .ctl_wdata  (ctl_wdata),
  .rd_en      (rd_en),
  .rd_sel     (rd_sel),
  .data_ready (data_ready),
  .irq_rx     (irq_rx),
  .irq_err    (irq_err),
  .fifo_en    (fifo_en),
  .occ        (occ),
  .err_bits   (err_bits)
);

// File: tb/uart_rxq_test.sv
module uart_rxq_test;

  localparam int DEPTH = 16;

  logic        clk;
  logic        rst_n;
  logic        rx_valid, rx_perr, rx_ferr, rx_break;
  logic [7:0]  rx_byte;
  logic        ctl_we;
  logic [1:0]  ctl_wdata;
  logic        src_clr_we;
  logic [1:0]  src_clr;
  logic        rd_en;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic        data_ready, irq_rx, irq_err;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  uart_rxq #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_break(rx_break),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .src_clr_we(src_clr_we), .src_clr(src_clr),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .data_ready(data_ready), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b, input logic perr = 1'b0);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b; rx_perr = perr;
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0;
  endtask

  task automatic send_break();
    @(negedge clk);
    rx_break = 1'b1;
    @(negedge clk);
    rx_break = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    #1 val = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [31:0] val);
    rd_sel = sel;
    #1 val = rd_data;
  endtask

  task automatic write_ctl(input logic [1:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic clear_src(input logic [1:0] m);
    @(negedge clk);
    src_clr_we = 1'b1; src_clr = m;
    @(negedge clk);
    src_clr_we = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 data_ready", 32'(data_ready), 0);
    chk("R1 irq_rx", 32'(irq_rx), 0);
    chk("R1 irq_err", 32'(irq_err), 0);
    peek(2'd3, v); chk("R1 ctrl word", v, 0);
    peek(2'd2, v); chk("R1 error word", v, 0);
    peek(2'd1, v); chk("R1 status word", v, 0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    push_byte(8'h41);
    push_byte(8'h42);
    chk("R6 data_ready set", 32'(data_ready), 1);
    chk("R6 data request", 32'(irq_rx), 1);
    read_reg(2'd0, v);
    chk("R6 latest byte kept", v, 32'h42);
    chk("R6 read clears ready", 32'(data_ready), 0);
    clear_src(2'b01);
    chk("R10 data request cleared", 32'(irq_rx), 0);
  endtask

  task automatic t_order();
    logic [31:0] v;
    write_ctl(2'b01);
    push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
    peek(2'd1, v); chk("R2 occupancy 3", v, 32'd3);
    read_reg(2'd0, v); chk("R2 first byte", v, 32'h11);
    chk("R5 ready while bytes remain", 32'(data_ready), 1);
    read_reg(2'd0, v); chk("R2 second byte", v, 32'h22);
    read_reg(2'd0, v); chk("R2 third byte", v, 32'h33);
    chk("R5 ready drops when empty", 32'(data_ready), 0);
  endtask

  task automatic t_full();
    logic [31:0] v;
    clear_src(2'b11);
    for (int i = 0; i < DEPTH; i++) push_byte(8'(i + 8'h80));
    peek(2'd1, v); chk("R3 full status word", v, 32'h100);
    chk("R3 no error before overflow", 32'(irq_err), 0);
    push_byte(8'hEE);
    chk("R3 overflow error request", 32'(irq_err), 1);
    chk("R3 ready stays high", 32'(data_ready), 1);
    peek(2'd2, v); chk("R3 overrun bit", v, 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      read_reg(2'd0, v);
      chk("R3 drain order, dropped byte absent", v, 32'(8'(i + 8'h80)));
    end
    chk("R5 ready low after drain", 32'(data_ready), 0);
  endtask

  task automatic t_err_read();
    logic [31:0] v;
    peek(2'd1, v); chk("R8 status error bit", v, 32'h200);
    read_reg(2'd2, v); chk("R8 error word read", v, 32'h1);
    peek(2'd2, v); chk("R8 error word cleared", v, 0);
    peek(2'd1, v); chk("R8 status error bit cleared", v, 0);
  endtask

  task automatic t_underflow();
    logic [31:0] v;
    clear_src(2'b11);
    chk("R10 error request cleared", 32'(irq_err), 0);
    read_reg(2'd0, v); chk("R4 empty read returns 0", v, 0);
    chk("R4 underflow error request", 32'(irq_err), 1);
    peek(2'd1, v); chk("R4 occupancy stays 0", v, 0);
  endtask

  task automatic t_break();
    logic [31:0] v;
    push_byte(8'h55, 1'b1);
    send_break();
    peek(2'd1, v); chk("R7 break stored, status", v, 32'h202);
    peek(2'd2, v); chk("R7 R8 break and parity bits", v, 32'hA);
    read_reg(2'd0, v); chk("R7 byte before break", v, 32'h55);
    read_reg(2'd0, v); chk("R7 break zero byte", v, 0);
    read_reg(2'd2, v); chk("R8 read returns bits", v, 32'hA);
    peek(2'd2, v); chk("R8 cleared after read", v, 0);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    push_byte(8'h01); push_byte(8'h02);
    write_ctl(2'b11);
    peek(2'd1, v); chk("R9 flush empties queue", v, 0);
    chk("R9 ready low after flush", 32'(data_ready), 0);
    peek(2'd3, v); chk("R9 flush bit reads 0", v, 32'h1);
    push_byte(8'h77);
    read_reg(2'd0, v); chk("R9 queue usable after flush", v, 32'h77);
  endtask

  initial begin
    rst_n = 1'b0;
    rx_valid = 0; rx_byte = 0; rx_perr = 0; rx_ferr = 0; rx_break = 0;
    ctl_we = 0; ctl_wdata = 0; src_clr_we = 0; src_clr = 0;
    rd_en = 0; rd_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_order();
    t_full();
    t_err_read();
    t_underflow();
    t_break();
    t_flush();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule